// File: doc/BRIEF.md
# Interleaved 4:2:2 Video Deinterleaver

This block takes progressive-scan YCbCr 4:2:2 video that arrives as a single multiplexed 10-bit word stream and turns it back into a parallel luma/chroma pair. The words repeat as Cb, Y, Cr, Y. Lines are delimited by embedded timing references, and each reference carries a status word with field and blanking flags.

Two capture schemes are supported. In the half-rate scheme a word lands on every clock edge, rising and falling. In the full-rate scheme a word lands only on each rising edge. In the half-rate scheme an edge-polarity input says whether the chroma word or the luma word is the one taken on the rising edge. Falling-edge words are moved into the rising-edge domain at once, so all parsing and all outputs run on the rising edge.

For 8-bit sources the data sits on the upper eight lines. A narrow-source input masks the two low lines to zero and ignores them when references are detected. For each Y word the block emits one registered Y/C pair with a valid strobe, together with a flag that tells whether the paired chroma word was Cb or Cr.

Top module: `vid422_split`

## Requirements
- R1: Pixel words are taken in the repeating order Cb, Y, Cr, Y. Each Y word produces exactly one output with `out_valid` high. `c_out` holds the chroma word that came before it. `c_is_cr` is 0 when that chroma word was Cb and 1 when it was Cr.
- R2: A timing reference is the word run 3FF, 000, 000, status. The first pixel word after the status word is always taken as Cb, whatever phase the stream was in before.
- R3: The three reference words and the status word never appear as output data, and `out_valid` stays low for them. A 3FF word is never output as Y or C.
- R4: In the status word, bit 8 drives `field_flag`, bit 7 drives `vblank_flag` and bit 6 drives `hblank_flag`. Each flag holds its value until the next status word.
- R5: With `ddr_mode`=0, one word is captured on each rising clock edge. `out_valid` is never high on two cycles in a row.
- R6: With `ddr_mode`=1, one word is captured on each rising edge and one on each falling edge. The stream is parsed in time order.
- R7: With `ddr_mode`=1 and `rise_is_luma`=0, the Cb/Cr words and the first reference word arrive on rising edges. With `rise_is_luma`=1, the Y words arrive on rising edges.
- R8: With `narrow_src`=1, bits 1:0 of every input word are treated as zero. Those bits are zero on `y_out` and `c_out`, and they do not affect reference detection.
- R9: After reset, `out_valid` stays low until the first complete timing reference has been recognised.
- R10: Synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock (half-rate in dual-edge mode) |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | 1: word on both edges, 0: word on rising edge only |
| rise_is_luma | input | 1 | Dual-edge polarity: 1 puts Y on rising edges |
| narrow_src | input | 1 | 1: 8-bit source on the upper lines |
| pix_in | input | 10 | Multiplexed pixel and reference word bus |
| y_out | output | 10 | Recovered luma word |
| c_out | output | 10 | Chroma word paired with `y_out` |
| c_is_cr | output | 1 | 1 when `c_out` is Cr, 0 when Cb |
| out_valid | output | 1 | One-cycle strobe for each Y/C pair |
| field_flag | output | 1 | Field bit from the last status word |
| vblank_flag | output | 1 | Vertical-blank bit from the last status word |
| hblank_flag | output | 1 | Horizontal-blank bit from the last status word |

## Verification
The bench runs full-rate, both dual-edge polarities and 8-bit capture with noise on the low lines. A wrong edge pairing would swap Y and C or emit them one word out of step. Unmasked low bits would corrupt data or break 8-bit reference detection. A stray chroma word is placed just before a reference: a parser that fails to realign on the reference would pair every later Y with the wrong chroma and flip `c_is_cr`. Pixel words sent before the first reference, and the reference words themselves, must not produce output. A leak would leave unmatched outputs in the scoreboard, and a lost Y would leave an expected item in the queue at the end.

// File: rtl/vid422_pkg.sv
package vid422_pkg;

  // Position inside the Cb, Y, Cr, Y cycle.
  typedef enum logic [1:0] {
    PH_CB = 2'd0,
    PH_Y0 = 2'd1,
    PH_CR = 2'd2,
    PH_Y1 = 2'd3
  } ph_e;

  typedef struct packed {
    logic fld;
    logic vbl;
    logic hbl;
  } sync_t;

  // Parser state carried from word to word.
  typedef struct packed {
    logic       locked;  // a full reference has been seen since reset
    ph_e        ph;
    logic [1:0] pre;     // reference words matched so far
    sync_t      sy;
  } pst_t;

endpackage

// File: rtl/vid422_capture.sv
module vid422_capture #(
  parameter int DW = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ddr_mode,
  input  logic                rise_is_luma,
  input  logic [DW-1:0]       pix_in,
  output logic [1:0][DW-1:0]  words   // [0] earlier in time, [1] later
);

  logic [DW-1:0] fall_q;    // falling-edge capture
  logic [DW-1:0] s_rise;    // word taken at the current rising edge
  logic [DW-1:0] s_fall;    // falling-edge word moved to the rising domain
  logic [DW-1:0] s_rise_d;  // rising word one cycle older

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= pix_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_rise   <= '0;
      s_fall   <= '0;
      s_rise_d <= '0;
    end else begin
      s_rise   <= pix_in;
      s_fall   <= fall_q;
      s_rise_d <= s_rise;
    end
  end

  // Pair words so the chroma-slot word comes first in time.
  always_comb begin
    if (!ddr_mode) begin
      words[0] = s_rise;
      words[1] = s_rise;
    end else if (rise_is_luma) begin
      words[0] = s_fall;
      words[1] = s_rise;
    end else begin
      words[0] = s_rise_d;
      words[1] = s_fall;
    end
  end

endmodule

// File: rtl/vid422_lane.sv
module vid422_lane
  import vid422_pkg::*;
#(
  parameter int DW      = 10,
  parameter int NLSB    = 2,
  parameter int FLD_BIT = 8,
  parameter int VBL_BIT = 7,
  parameter int HBL_BIT = 6
) (
  input  logic          en,
  input  logic          narrow,
  input  logic [DW-1:0] word,
  input  pst_t          st_i,
  input  logic [DW-1:0] hold_i,
  output pst_t          st_o,
  output logic [DW-1:0] hold_o,
  output logic          emit,
  output logic [DW-1:0] y,
  output logic [DW-1:0] c,
  output logic          is_cr
);

  localparam logic [DW-1:0] LOW_MASK = {{(DW-NLSB){1'b0}}, {NLSB{1'b1}}};

  logic [DW-1:0] w;
  logic          ones;
  logic          zero;
  logic [1:0]    ph_nx;

  always_comb begin
    w     = narrow ? (word & ~LOW_MASK) : word;
    ones  = narrow ? &(word | LOW_MASK) : &word;
    zero  = ~|w;
    ph_nx = st_i.ph + 2'd1;

    st_o   = st_i;
    hold_o = hold_i;
    emit   = 1'b0;
    y      = w;
    c      = hold_i;
    is_cr  = 1'b0;

    if (en) begin
      if (st_i.pre == 2'd3) begin
        // status word closes the reference
        st_o.sy.fld = w[FLD_BIT];
        st_o.sy.vbl = w[VBL_BIT];
        st_o.sy.hbl = w[HBL_BIT];
        st_o.ph     = PH_CB;
        st_o.pre    = 2'd0;
        st_o.locked = 1'b1;
      end else if (ones) begin
        st_o.pre = 2'd1;
      end else if (zero && st_i.pre != 2'd0) begin
        st_o.pre = st_i.pre + 2'd1;
      end else begin
        st_o.pre = 2'd0;
        st_o.ph  = ph_e'(ph_nx);
        unique case (st_i.ph)
          PH_CB, PH_CR: hold_o = w;
          PH_Y0, PH_Y1: begin
            emit  = st_i.locked;
            is_cr = (st_i.ph == PH_Y1);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/vid422_parse.sv
module vid422_parse
  import vid422_pkg::*;
#(
  parameter int DW    = 10,
  parameter int LANES = 2,
  parameter int NLSB  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ddr_mode,
  input  logic                   narrow,
  input  logic [LANES-1:0][DW-1:0] words,
  output logic [DW-1:0]          y_out,
  output logic [DW-1:0]          c_out,
  output logic                   c_is_cr,
  output logic                   out_valid,
  output sync_t                  sync_out
);

  pst_t          st_q;
  logic [DW-1:0] hold_q;

  pst_t          st_ch   [LANES+1];
  logic [DW-1:0] hold_ch [LANES+1];
  logic [LANES-1:0] emit_v;
  logic [LANES-1:0] cr_v;
  logic [DW-1:0] y_v [LANES];
  logic [DW-1:0] c_v [LANES];

  assign st_ch[0]   = st_q;
  assign hold_ch[0] = hold_q;

  // One step per word; the second lane is only used with two words a cycle.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit FIRST = (i == 0);
    vid422_lane #(.DW(DW), .NLSB(NLSB)) u_lane (
      .en     (FIRST | ddr_mode),
      .narrow (narrow),
      .word   (words[i]),
      .st_i   (st_ch[i]),
      .hold_i (hold_ch[i]),
      .st_o   (st_ch[i+1]),
      .hold_o (hold_ch[i+1]),
      .emit   (emit_v[i]),
      .y      (y_v[i]),
      .c      (c_v[i]),
      .is_cr  (cr_v[i])
    );
  end

  logic          sel_emit;
  logic [DW-1:0] sel_y;
  logic [DW-1:0] sel_c;
  logic          sel_cr;

  // Y words alternate with chroma, so at most one lane emits per cycle.
  always_comb begin
    sel_emit = |emit_v;
    sel_y    = y_v[0];
    sel_c    = c_v[0];
    sel_cr   = cr_v[0];
    for (int i = 1; i < LANES; i++) begin
      if (emit_v[i]) begin
        sel_y  = y_v[i];
        sel_c  = c_v[i];
        sel_cr = cr_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= '0;
      hold_q    <= '0;
      y_out     <= '0;
      c_out     <= '0;
      c_is_cr   <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      st_q      <= st_ch[LANES];
      hold_q    <= hold_ch[LANES];
      out_valid <= sel_emit;
      if (sel_emit) begin
        y_out   <= sel_y;
        c_out   <= sel_c;
        c_is_cr <= sel_cr;
      end
    end
  end

  assign sync_out = st_q.sy;

endmodule

// File: rtl/vid422_split.sv
module vid422_split
  import vid422_pkg::*;
#(
  parameter int DW   = 10,
  parameter int NLSB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ddr_mode,
  input  logic          rise_is_luma,
  input  logic          narrow_src,
  input  logic [DW-1:0] pix_in,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] c_out,
  output logic          c_is_cr,
  output logic          out_valid,
  output logic          field_flag,
  output logic          vblank_flag,
  output logic          hblank_flag
);

  localparam int LANES = 2;  // one word per clock edge

  logic [LANES-1:0][DW-1:0] words;
  sync_t                    sync_q;

  vid422_capture #(.DW(DW)) u_cap (
    .clk          (clk),
    .rst          (rst),
    .ddr_mode     (ddr_mode),
    .rise_is_luma (rise_is_luma),
    .pix_in       (pix_in),
    .words        (words)
  );

  vid422_parse #(.DW(DW), .LANES(LANES), .NLSB(NLSB)) u_parse (
    .clk       (clk),
    .rst       (rst),
    .ddr_mode  (ddr_mode),
    .narrow    (narrow_src),
    .words     (words),
    .y_out     (y_out),
    .c_out     (c_out),
    .c_is_cr   (c_is_cr),
    .out_valid (out_valid),
    .sync_out  (sync_q)
  );

  assign field_flag  = sync_q.fld;
  assign vblank_flag = sync_q.vbl;
  assign hblank_flag = sync_q.hbl;

endmodule

// File: rtl/vid422_split_chk.sv
module vid422_split_chk #(
  parameter int DW   = 10,
  parameter int NLSB = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ddr_mode,
  input logic          narrow_src,
  input logic [DW-1:0] pix_in,
  input logic [DW-1:0] y_out,
  input logic [DW-1:0] c_out,
  input logic          out_valid
);

  logic ones_now;
  logic seen_r;
  logic seen_f;

  assign ones_now = narrow_src ? &pix_in[DW-1:NLSB] : &pix_in;

  always_ff @(posedge clk) begin
    if (rst)           seen_r <= 1'b0;
    else if (ones_now) seen_r <= 1'b1;
  end

  always_ff @(negedge clk) begin
    if (rst)           seen_f <= 1'b0;
    else if (ones_now) seen_f <= 1'b1;
  end

  // R5: full-rate capture never yields back-to-back pairs
  p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (rst)
    (!ddr_mode && out_valid) |=> (ddr_mode || !out_valid));

  // R8: low lines are masked for 8-bit sources
  p_low_bits_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (narrow_src && out_valid) |-> (y_out[NLSB-1:0] == '0 && c_out[NLSB-1:0] == '0));

  // R3: an all-ones reference word is never output as pixel data
  p_ref_never_pixel_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !narrow_src) |-> (y_out != '1 && c_out != '1));

  // R9: no output before a reference start has been on the bus
  p_quiet_until_ref_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen_r || seen_f));

endmodule

bind vid422_split vid422_split_chk #(.DW(DW), .NLSB(NLSB)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ddr_mode   (ddr_mode),
  .narrow_src (narrow_src),
  .pix_in     (pix_in),
  .y_out      (y_out),
  .c_out      (c_out),
  .out_valid  (out_valid)
);

// File: tb/vid422_split_test.sv
module vid422_split_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ddr_mode = 1'b0;
  logic       rise_is_luma = 1'b0;
  logic       narrow_src = 1'b0;
  logic [9:0] pix_in = 10'h3FF;
  logic [9:0] y_out, c_out;
  logic       c_is_cr, out_valid, field_flag, vblank_flag, hblank_flag;

  vid422_split uut (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .rise_is_luma(rise_is_luma),
    .narrow_src(narrow_src), .pix_in(pix_in), .y_out(y_out), .c_out(c_out),
    .c_is_cr(c_is_cr), .out_valid(out_valid), .field_flag(field_flag),
    .vblank_flag(vblank_flag), .hblank_flag(hblank_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct packed {
    logic [9:0] y;
    logic [9:0] c;
    logic       cr;
    logic       f;
    logic       v;
    logic       h;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  bit    rise_next = 1'b1;
  bit    cur_f, cur_v, cur_h;
  string req_tag = "R9";
  string cfg_tag = "R5";
  int    seq = 0;

  // Drive one word on the next capture edge.
  task automatic put_word(input logic [9:0] w);
    if (ddr_mode) begin
      if (rise_next) @(negedge clk);
      else           @(posedge clk);
      rise_next = !rise_next;
    end else begin
      @(negedge clk);
    end
    #1;
    pix_in = w;
  endtask

  function automatic logic [9:0] drv(input logic [9:0] v);
    return narrow_src ? {v[9:2], v[3:2] ^ 2'b01} : v;
  endfunction

  function automatic logic [9:0] expv(input logic [9:0] v);
    return narrow_src ? {v[9:2], 2'b00} : v;
  endfunction

  function automatic logic [9:0] pv(input int n);
    return 10'h040 + 10'((n * 37) % 800);
  endfunction

  task automatic send_ref(input bit f, input bit v, input bit h);
    put_word(drv(10'h3FF));
    put_word(drv(10'h000));
    put_word(drv(10'h000));
    cur_f = f; cur_v = v; cur_h = h;
    put_word(drv({1'b1, f, v, h, 4'b0101, 2'b00}));
  endtask

  task automatic push_exp(input logic [9:0] y, input logic [9:0] c, input bit cr);
    exp_t e;
    e.y = expv(y); e.c = expv(c); e.cr = cr;
    e.f = cur_f; e.v = cur_v; e.h = cur_h;
    q.push_back(e);
  endtask

  task automatic send_group();
    logic [9:0] cb, y0, cr, y1;
    cb = pv(seq); y0 = pv(seq + 1); cr = pv(seq + 2); y1 = pv(seq + 3);
    seq += 4;
    put_word(drv(cb));
    push_exp(y0, cb, 1'b0);
    put_word(drv(y0));
    put_word(drv(cr));
    push_exp(y1, cr, 1'b1);
    put_word(drv(y1));
  endtask

  // Scoreboard monitor, sampling away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (!rst && out_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL %s [%s]: output y=%h c=%h, expected none", req_tag, cfg_tag, y_out, c_out);
      end else begin
        e = q.pop_front();
        if (y_out != e.y || c_out != e.c || c_is_cr != e.cr) begin
          errors++;
          $display("FAIL R1 [%s]: y=%h c=%h cr=%0b, expected y=%h c=%h cr=%0b",
                   cfg_tag, y_out, c_out, c_is_cr, e.y, e.c, e.cr);
        end
        checks++;
        if ({field_flag, vblank_flag, hblank_flag} != {e.f, e.v, e.h}) begin
          errors++;
          $display("FAIL R4 [%s]: flags=%b, expected %b", cfg_tag,
                   {field_flag, vblank_flag, hblank_flag}, {e.f, e.v, e.h});
        end
      end
    end
  end

  task automatic run_cfg(input bit d, input bit p, input bit n, input string tag);
    rst = 1'b1;
    pix_in = 10'h3FF;
    ddr_mode = d; rise_is_luma = p; narrow_src = n;
    cfg_tag = tag;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (out_valid || y_out != 0 || c_out != 0 || c_is_cr ||
        field_flag || vblank_flag || hblank_flag) begin
      errors++;
      $display("FAIL R10 [%s]: v=%0b y=%h c=%h cr=%0b flags=%b, expected all zero", tag,
               out_valid, y_out, c_out, c_is_cr, {field_flag, vblank_flag, hblank_flag});
    end
    #1 rst = 1'b0;
    rise_next = !p;  // R7: chroma slot lands on the rising edge when p is 0
    // R9: pixels before any reference give no output
    req_tag = "R9";
    for (int k = 0; k < 4; k++) put_word(drv(pv(900 + k)));
    req_tag = "R3";
    send_ref(1'b0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) send_group();
    send_ref(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 2; k++) send_group();
    send_ref(1'b0, 1'b1, 1'b1);
    send_group();
    // R2: stray chroma word, the reference must realign to Cb
    put_word(drv(pv(seq)));
    push_exp(pv(seq + 1), pv(seq), 1'b0);
    put_word(drv(pv(seq + 1)));
    put_word(drv(pv(seq + 2)));
    seq += 3;
    req_tag = "R2";
    send_ref(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 2; k++) send_group();
    put_word(drv(10'h3FF));
    put_word(drv(10'h3FF));
    repeat (8) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 [%s]: %0d pairs missing, expected 0", tag, q.size());
      q.delete();
    end
  endtask

  bit done = 1'b0;

  initial begin
    run_cfg(1'b0, 1'b0, 1'b0, "R5");
    run_cfg(1'b1, 1'b0, 1'b0, "R6 R7 rise=Cb");
    run_cfg(1'b1, 1'b1, 1'b0, "R6 R7 rise=Y");
    run_cfg(1'b1, 1'b1, 1'b1, "R8 ddr");
    run_cfg(1'b0, 1'b0, 1'b1, "R8 sdr");
    run_cfg(1'b1, 1'b0, 1'b1, "R8 ddr rise=Cb");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule